// File: doc/BRIEF.md
# Segmented Pre-Trigger Capture Controller

This block steers the writing of samples from two digitizer channels into a shared waveform memory. Both channels run on one sample-clock enable, so every accepted sample pair lands at a single address. The block also produces the write strobe, the address and the two data bytes for the memory array, which sits outside it.

Once armed, the block fills the current segment as a ring buffer. A trigger is accepted only after enough pre-trigger samples have been collected. The trigger comes from a software pulse or from an edge on the external trigger line, and the polarity of that edge can be chosen. The write offset at which the trigger arrives is stored as the trigger address. After an optional hold-off, counted in sample enables with no writes, the rest of the segment is filled with post-trigger samples. The block then raises done and disarms.

Software moves on to the next segment with an advance pulse while the block is not armed. This gives one event per segment, across as many as 4096 segments. Segment size, active memory size and pre-trigger length are all set in blocks of 16 samples.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, armed_o, triggered_o and done_o are 0, and trig_addr_o and seg_idx_o are 0.
- R2: An arm_i pulse while not armed sets armed_o on the next cycle, clears done_o, and restarts writing at offset 0 of the current segment. An arm_i pulse while already armed is ignored.
- R3: While writing (armed and not triggered, or in the post-trigger phase), wr_en_o equals sample_en_i in the same cycle. In every other state wr_en_o is 0. When wr_en_o is 1, wr_ch0_o and wr_ch1_o carry ch0_i and ch1_i, and both bytes share wr_addr_o.
- R4: wr_addr_o is the segment base plus a write offset. The offset advances by one on each write and wraps from seglen-1 to 0, where seglen = (cfg_seg_m1_i+1)*16.
- R5: A trigger is accepted only while armed and not triggered, and only once at least prelen samples have been written since arming, where prelen = min(cfg_pre_blk_i*16, seglen). An earlier trigger has no effect. The sample offered in the cycle of an accepted trigger is not written.
- R6: A trigger event is either sw_trig_i high in a cycle or an edge of ext_trig_i. With trig_pol_i=0 the edge is rising; with trig_pol_i=1 the edge is falling.
- R7: On acceptance, trig_addr_o takes the value segment base + current write offset, which is the address of the first post-trigger sample.
- R8: After acceptance, triggered_o is 1. The next cfg_holdoff_i sample enables are skipped without writes, and then post-trigger writing starts at the trigger address.
- R9: Exactly seglen-prelen post-trigger samples are written. After the last one, done_o becomes 1 and armed_o and triggered_o become 0. When prelen equals seglen, done_o is set on the cycle after acceptance.
- R10: A seg_adv_i pulse while idle, with no arm_i or abort_i in the same cycle, increments seg_idx_o and moves the base up by seglen. Both wrap to 0 when seg_idx_o is 4095 or when the following segment would end beyond memlen = (cfg_mem_m1_i+1)*16. The pulse is ignored while armed.
- R11: abort_i in any state returns the block on the next cycle to the state it has after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm pulse |
| abort_i | input | 1 | Abort pulse, returns everything to idle |
| sw_trig_i | input | 1 | Software trigger pulse |
| ext_trig_i | input | 1 | External trigger level |
| trig_pol_i | input | 1 | Trigger edge select: 0 = rising, 1 = falling |
| seg_adv_i | input | 1 | Advance to the next segment |
| sample_en_i | input | 1 | Sample clock enable |
| ch0_i | input | 8 | Channel 0 sample |
| ch1_i | input | 8 | Channel 1 sample |
| cfg_mem_m1_i | input | 13 | Active memory size in 16-sample blocks, minus one |
| cfg_seg_m1_i | input | 13 | Segment size in 16-sample blocks, minus one |
| cfg_pre_blk_i | input | 14 | Pre-trigger length in 16-sample blocks |
| cfg_holdoff_i | input | 18 | Hold-off length in sample enables |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 17 | Memory write address |
| wr_ch0_o | output | 8 | Channel 0 write data |
| wr_ch1_o | output | 8 | Channel 1 write data |
| trig_addr_o | output | 17 | Latched trigger address |
| seg_idx_o | output | 12 | Current segment number |
| armed_o | output | 1 | Armed status |
| triggered_o | output | 1 | Triggered status |
| done_o | output | 1 | Record complete |

## Verification
The hardest cases to reach from the ports are those where several limits meet. One is a trigger arriving just as the pre-trigger fill count reaches its threshold. Others are the 4096-segment roll-over and an abort in the middle of the post-trigger phase. The stimulus reaches the roll-over with a directed run of 4096 advance pulses on a 16-sample segment. Further directed sequences cover early triggers, the polarity-masked external edge, the hold-off gap and an abort during the post-trigger phase. A long seeded random phase then mixes arms, aborts, triggers and small configurations, so that triggers land on and around the fill threshold many times.

// File: rtl/capture_pkg.sv
`timescale 1ns/1ps
package capture_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_HOLD = 2'd2,
        ST_POST = 2'd3
    } cap_state_e;
endpackage

// File: rtl/capture_len_calc.sv
`timescale 1ns/1ps
module capture_len_calc #(
    parameter int ADDR_W    = 17,
    parameter int BLK_SHIFT = 4,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT,
    localparam int LEN_W    = ADDR_W + 1
) (
    input  logic [BLK_W-1:0] cfg_seg_m1_i,
    input  logic [BLK_W-1:0] cfg_mem_m1_i,
    input  logic [BLK_W:0]   cfg_pre_blk_i,
    output logic [LEN_W-1:0] seg_len_o,
    output logic [LEN_W-1:0] mem_len_o,
    output logic [LEN_W-1:0] pre_len_o,
    output logic [LEN_W-1:0] post_len_o
);
    logic [LEN_W-1:0] pre_raw;

    always_comb begin
        seg_len_o  = (LEN_W'(cfg_seg_m1_i) + LEN_W'(1)) << BLK_SHIFT;
        mem_len_o  = (LEN_W'(cfg_mem_m1_i) + LEN_W'(1)) << BLK_SHIFT;
        pre_raw    = LEN_W'(cfg_pre_blk_i) << BLK_SHIFT;
        pre_len_o  = (pre_raw > seg_len_o) ? seg_len_o : pre_raw;
        post_len_o = seg_len_o - pre_len_o;
    end
endmodule

// File: rtl/capture_trig_sel.sv
`timescale 1ns/1ps
module capture_trig_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic pol_i,
    input  logic sw_i,
    output logic trig_o
);
    logic lvl;
    logic prev_d, prev_q;

    always_comb begin
        lvl    = ext_i ^ pol_i;
        prev_d = lvl;
        trig_o = (lvl & ~prev_q) | sw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/capture_seg_base.sv
`timescale 1ns/1ps
module capture_seg_base #(
    parameter int ADDR_W = 17,
    parameter int SEG_W  = 12,
    localparam int LEN_W = ADDR_W + 1,
    localparam int SUM_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [LEN_W-1:0]  seg_len_i,
    input  logic [LEN_W-1:0]  mem_len_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [SEG_W-1:0]  idx_o
);
    logic [ADDR_W-1:0] base_d, base_q;
    logic [SEG_W-1:0]  idx_d, idx_q;
    logic [SUM_W-1:0]  nxt_base, nxt_end;
    logic              wrap;

    always_comb begin
        nxt_base = SUM_W'(base_q) + SUM_W'(seg_len_i);
        nxt_end  = nxt_base + SUM_W'(seg_len_i);
        wrap     = (&idx_q) || (nxt_end > SUM_W'(mem_len_i));
        base_d   = base_q;
        idx_d    = idx_q;
        if (clr_i) begin
            base_d = '0;
            idx_d  = '0;
        end else if (adv_i) begin
            base_d = wrap ? '0 : nxt_base[ADDR_W-1:0];
            idx_d  = wrap ? '0 : idx_q + SEG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else begin
            base_q <= base_d;
            idx_q  <= idx_d;
        end
    end

    assign base_o = base_q;
    assign idx_o  = idx_q;

    // R10
    base_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(base_q) |-> $past(adv_i || clr_i));
endmodule

// File: rtl/capture_ctrl.sv
`timescale 1ns/1ps
module capture_ctrl #(
    parameter int ADDR_W    = 17,
    parameter int SAMPLE_W  = 8,
    parameter int BLK_SHIFT = 4,
    parameter int SEG_W     = 12,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT,
    localparam int LEN_W    = ADDR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_i,
    input  logic                abort_i,
    input  logic                sw_trig_i,
    input  logic                ext_trig_i,
    input  logic                trig_pol_i,
    input  logic                seg_adv_i,
    input  logic                sample_en_i,
    input  logic [SAMPLE_W-1:0] ch0_i,
    input  logic [SAMPLE_W-1:0] ch1_i,
    input  logic [BLK_W-1:0]    cfg_mem_m1_i,
    input  logic [BLK_W-1:0]    cfg_seg_m1_i,
    input  logic [BLK_W:0]      cfg_pre_blk_i,
    input  logic [LEN_W-1:0]    cfg_holdoff_i,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [SAMPLE_W-1:0] wr_ch0_o,
    output logic [SAMPLE_W-1:0] wr_ch1_o,
    output logic [ADDR_W-1:0]   trig_addr_o,
    output logic [SEG_W-1:0]    seg_idx_o,
    output logic                armed_o,
    output logic                triggered_o,
    output logic                done_o
);
    import capture_pkg::*;

    typedef struct packed {
        cap_state_e        st;
        logic              done;
        logic [ADDR_W-1:0] off;
        logic [LEN_W-1:0]  fill;
        logic [LEN_W-1:0]  hold;
        logic [LEN_W-1:0]  post;
        logic [ADDR_W-1:0] taddr;
    } regs_t;

    regs_t d, q;

    logic [LEN_W-1:0]  seg_len, mem_len, pre_len, post_len;
    logic [LEN_W-1:0]  off_nx;
    logic [ADDR_W-1:0] base;
    logic              trig_evt, trig_ok, adv_go, wr_en;

    capture_len_calc #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_len (
        .cfg_seg_m1_i (cfg_seg_m1_i),
        .cfg_mem_m1_i (cfg_mem_m1_i),
        .cfg_pre_blk_i(cfg_pre_blk_i),
        .seg_len_o    (seg_len),
        .mem_len_o    (mem_len),
        .pre_len_o    (pre_len),
        .post_len_o   (post_len)
    );

    capture_trig_sel u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .ext_i (ext_trig_i),
        .pol_i (trig_pol_i),
        .sw_i  (sw_trig_i),
        .trig_o(trig_evt)
    );

    capture_seg_base #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (abort_i),
        .adv_i    (adv_go),
        .seg_len_i(seg_len),
        .mem_len_i(mem_len),
        .base_o   (base),
        .idx_o    (seg_idx_o)
    );

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        adv_go  = 1'b0;
        off_nx  = LEN_W'(q.off) + LEN_W'(1);
        trig_ok = (q.st == ST_PRE) && trig_evt && (q.fill >= pre_len);
        if (abort_i) begin
            d = '0;
        end else if (arm_i && (q.st == ST_IDLE)) begin
            d.st   = ST_PRE;
            d.done = 1'b0;
            d.off  = '0;
            d.fill = '0;
        end else begin
            case (q.st)
                ST_IDLE: adv_go = seg_adv_i;
                ST_PRE: begin
                    if (trig_ok) begin
                        d.taddr = base + q.off;
                        d.post  = post_len;
                        if (post_len == '0) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else if (cfg_holdoff_i != '0) begin
                            d.st   = ST_HOLD;
                            d.hold = cfg_holdoff_i;
                        end else begin
                            d.st = ST_POST;
                        end
                    end else if (sample_en_i) begin
                        wr_en  = 1'b1;
                        d.off  = (off_nx >= seg_len) ? '0 : off_nx[ADDR_W-1:0];
                        d.fill = (q.fill >= pre_len) ? pre_len : q.fill + LEN_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (sample_en_i) begin
                        if (q.hold == LEN_W'(1)) d.st = ST_POST;
                        d.hold = q.hold - LEN_W'(1);
                    end
                end
                ST_POST: begin
                    if (sample_en_i) begin
                        wr_en  = 1'b1;
                        d.off  = (off_nx >= seg_len) ? '0 : off_nx[ADDR_W-1:0];
                        d.post = q.post - LEN_W'(1);
                        if (q.post == LEN_W'(1)) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end
                end
                default: d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en_o     = wr_en;
    assign wr_addr_o   = base + q.off;
    assign wr_ch0_o    = ch0_i;
    assign wr_ch1_o    = ch1_i;
    assign trig_addr_o = q.taddr;
    assign armed_o     = (q.st != ST_IDLE);
    assign triggered_o = (q.st == ST_HOLD) || (q.st == ST_POST);
    assign done_o      = q.done;

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!armed_o && !triggered_o && !done_o && trig_addr_o == '0));

    // R4
    wr_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (LEN_W'(q.off) < seg_len));

    // R5
    trig_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered_o) |-> $past(q.fill >= pre_len));

    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(q.st == ST_PRE || q.st == ST_POST));
endmodule

// File: tb/capture_ctrl_bench.sv
`timescale 1ns/1ps
module capture_ctrl_bench;
    localparam int AMASK = (1 << 17) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, abort = 0, sw = 0, ext = 0, pol = 0, adv = 0, sen = 0;
    logic [7:0]  ch0 = 0, ch1 = 0;
    logic [12:0] mem_m1 = 13'd7, seg_m1 = 13'd1;
    logic [13:0] pre_blk = 14'd1;
    logic [17:0] hold = 18'd0;

    logic        wr_en, armed, triggered, done;
    logic [16:0] wr_addr, trig_addr;
    logic [7:0]  wr_ch0, wr_ch1;
    logic [11:0] seg_idx;

    int n_chk = 0, n_bad = 0;
    bit fin = 0;

    int m_st, m_done, m_off, m_fill, m_hold, m_post, m_base, m_idx, m_taddr, m_prev;

    always #2.5 clk = ~clk;

    capture_ctrl u_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .abort_i(abort), .sw_trig_i(sw),
        .ext_trig_i(ext), .trig_pol_i(pol), .seg_adv_i(adv), .sample_en_i(sen),
        .ch0_i(ch0), .ch1_i(ch1), .cfg_mem_m1_i(mem_m1), .cfg_seg_m1_i(seg_m1),
        .cfg_pre_blk_i(pre_blk), .cfg_holdoff_i(hold),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_ch0_o(wr_ch0), .wr_ch1_o(wr_ch1),
        .trig_addr_o(trig_addr), .seg_idx_o(seg_idx), .armed_o(armed),
        .triggered_o(triggered), .done_o(done)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int seg_len_f();
        return (int'(seg_m1) + 1) * 16;
    endfunction

    function automatic int pre_len_f();
        int p = int'(pre_blk) * 16;
        return (p > seg_len_f()) ? seg_len_f() : p;
    endfunction

    task automatic model_clear();
        m_st = 0; m_done = 0; m_off = 0; m_fill = 0; m_hold = 0;
        m_post = 0; m_base = 0; m_idx = 0; m_taddr = 0;
    endtask

    // one clock cycle: check outputs at the falling edge, advance the model at the rising edge
    task automatic step();
        int sl, pl, ol, ml, lvl, nb, exp_we;
        bit evt, tok;
        sl = seg_len_f(); pl = pre_len_f(); ol = sl - pl;
        ml = (int'(mem_m1) + 1) * 16;
        lvl = int'(ext ^ pol);
        evt = ((lvl == 1) && (m_prev == 0)) || sw;
        tok = (m_st == 1) && evt && (m_fill >= pl);
        exp_we = 0;
        if (!abort && !(arm && m_st == 0)) begin
            if (m_st == 1 && !tok && sen) exp_we = 1;
            if (m_st == 3 && sen) exp_we = 1;
        end
        @(negedge clk);
        chk("R3 write strobe", wr_en, exp_we);
        if (exp_we == 1) begin
            chk("R4 write address", wr_addr, (m_base + m_off) & AMASK);
            chk("R3 channel 0 data", wr_ch0, ch0);
            chk("R3 channel 1 data", wr_ch1, ch1);
        end
        chk("R2 armed", armed, m_st != 0);
        chk("R8 triggered", triggered, m_st >= 2);
        chk("R9 done", done, m_done);
        chk("R7 trigger address", trig_addr, m_taddr);
        chk("R10 segment index", seg_idx, m_idx);
        @(posedge clk);
        m_prev = lvl;
        if (abort) model_clear();
        else if (arm && m_st == 0) begin
            m_st = 1; m_done = 0; m_off = 0; m_fill = 0;
        end else begin
            case (m_st)
                0: if (adv) begin
                    nb = m_base + sl;
                    if (m_idx == 4095 || nb + sl > ml) begin m_base = 0; m_idx = 0; end
                    else begin m_base = nb; m_idx++; end
                end
                1: if (tok) begin
                    m_taddr = (m_base + m_off) & AMASK;
                    m_post = ol;
                    if (ol == 0) begin m_st = 0; m_done = 1; end
                    else if (hold != 0) begin m_st = 2; m_hold = int'(hold); end
                    else m_st = 3;
                end else if (sen) begin
                    m_off = (m_off + 1 >= sl) ? 0 : m_off + 1;
                    m_fill = (m_fill < pl) ? m_fill + 1 : pl;
                end
                2: if (sen) begin
                    if (m_hold == 1) m_st = 3;
                    m_hold--;
                end
                3: if (sen) begin
                    m_off = (m_off + 1 >= sl) ? 0 : m_off + 1;
                    if (m_post == 1) begin m_st = 0; m_done = 1; end
                    m_post--;
                end
                default: ;
            endcase
        end
        #1;
    endtask

    task automatic quiet();
        arm = 0; abort = 0; sw = 0; adv = 0; sen = 0;
    endtask

    task automatic samples(int n);
        for (int i = 0; i < n; i++) begin
            quiet(); sen = 1; ch0 = 8'($urandom); ch1 = 8'($urandom);
            step();
        end
        quiet();
    endtask

    task automatic pulse_arm();
        quiet(); arm = 1; step(); quiet();
    endtask

    task automatic pulse_sw();
        quiet(); sw = 1; sen = 1; step(); quiet();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_clear();
        m_prev = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 armed after reset", armed, 0);
        chk("R1 triggered after reset", triggered, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 trigger address after reset", trig_addr, 0);
        chk("R1 segment index after reset", seg_idx, 0);

        // segment 32, pre 16, memory 128, no hold-off
        seg_m1 = 1; pre_blk = 1; mem_m1 = 7; hold = 0; pol = 0; ext = 0;
        pulse_arm();
        chk("R2 armed after arm", armed, 1);
        pulse_sw();
        chk("R5 early trigger ignored", triggered, 0);
        samples(18);
        pulse_arm();
        chk("R2 arm while armed keeps armed", armed, 1);
        samples(21);
        pulse_sw();
        chk("R6 software trigger accepted", triggered, 1);
        chk("R7 trigger address after wrap", trig_addr, 8);
        samples(15);
        chk("R9 not done before last post sample", done, 0);
        samples(1);
        chk("R9 done after post samples", done, 1);
        chk("R9 disarmed after post samples", armed, 0);

        // falling edge trigger with hold-off of 3
        pol = 1; hold = 3; quiet(); step();
        pulse_arm();
        chk("R2 done cleared by arm", done, 0);
        samples(16);
        ext = 1; step();
        chk("R6 masked edge ignored", triggered, 0);
        ext = 0; step();
        chk("R6 falling edge accepted", triggered, 1);
        chk("R7 trigger address at offset 16", trig_addr, 16);
        samples(3);
        chk("R8 still triggered after hold-off", triggered, 1);
        samples(16);
        chk("R9 done after hold-off record", done, 1);

        // pre-trigger clamped to the whole segment
        pol = 0; hold = 0; pre_blk = 5;
        pulse_arm();
        samples(31);
        pulse_sw();
        chk("R5 trigger before full pre-fill ignored", triggered, 0);
        samples(1);
        pulse_sw();
        chk("R9 full pre-trigger gives done at once", done, 1);
        chk("R9 full pre-trigger not triggered", triggered, 0);

        // segment advance
        pre_blk = 1;
        quiet(); adv = 1; step(); quiet();
        chk("R10 advance to segment 1", seg_idx, 1);
        pulse_arm();
        quiet(); adv = 1; step(); quiet();
        chk("R10 advance ignored while armed", seg_idx, 1);
        samples(16);
        pulse_sw();
        chk("R7 trigger address in segment 1", trig_addr, 48);
        samples(16);
        quiet(); adv = 1; step(); step(); quiet();
        chk("R10 advance to segment 3", seg_idx, 3);
        adv = 1; step(); quiet();
        chk("R10 wrap at end of active memory", seg_idx, 0);

        // abort in the post-trigger phase
        pulse_arm();
        samples(16);
        pulse_sw();
        samples(5);
        quiet(); abort = 1; step(); quiet();
        chk("R11 abort clears armed", armed, 0);
        chk("R11 abort clears triggered", triggered, 0);
        chk("R11 abort clears done", done, 0);
        chk("R11 abort clears trigger address", trig_addr, 0);

        // 4096 segment roll-over
        seg_m1 = 0; mem_m1 = 13'd8191; pre_blk = 0;
        quiet(); adv = 1;
        for (int i = 0; i < 4095; i++) step();
        chk("R10 reaches segment 4095", seg_idx, 4095);
        step(); quiet();
        chk("R10 rolls over after 4096 segments", seg_idx, 0);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            if (m_st == 0 && ($urandom % 20) == 0) begin
                seg_m1 = 13'($urandom % 4);
                mem_m1 = seg_m1 + 13'($urandom % 12);
                pre_blk = 14'($urandom % 6);
                hold = 18'($urandom % 5);
                pol = 1'($urandom);
            end
            arm = (($urandom % 30) == 0);
            abort = (($urandom % 300) == 0);
            sw = (($urandom % 40) == 0);
            adv = (($urandom % 25) == 0);
            sen = (($urandom % 10) < 7);
            if (($urandom % 8) == 0) ext = ~ext;
            ch0 = 8'($urandom); ch1 = 8'($urandom);
            step();
        end
        quiet(); step();

        fin = 1;
        summary();
        $finish;
    end
endmodule